// File: doc/BRIEF.md
# Dual-Target Bootloader Entry Sequencer

This block sits between a serial adapter's two pairs of handshake lines and two target microcontrollers that share one open-drain reset net. Each channel has a boot-request and a reset-request input, both active low. A host asks a target to enter its bootloader with three edges in a fixed order. First the boot request falls, then the reset request falls, then the reset request rises. When the block sees that order, it holds the target's boot-select pin low and plays a timed pulse on the shared reset line. It then releases the boot pin after a hold time set for that target.

The first channel to arm owns the block. The other channel is ignored until an inactivity timeout puts everything back to idle. Any edge that does not fit the expected next step parks the block until that same timeout expires. After power-up the block ignores all requests for a startup window, so glitches from the adapter's start-up are masked. All timing is set by parameters: a tick prescaler for the slow windows, and clock-cycle counts for the pulse phases.

Top module: `boot_entry_seq`

## Requirements
- R1: After reset, both boot_sel bits are 1, rst_oe is 0 and busy is 0.
- R2: Edges that occur during the first STARTUP_TICKS ticks after reset have no effect. A channel half-armed during that window produces no pulse later.
- R3: In idle, only a falling edge on boot_req_n arms a channel. Reset-request edges in idle have no effect.
- R4: Once channel 0 or 1 is armed, edges on the other channel have no effect until the block returns to idle. If both boot requests fall in the same cycle, channel 0 (index 0) wins. At most one boot_sel bit is ever 0.
- R5: On the armed channel, a falling edge of rst_req_n followed by its rising edge starts exactly one reset sequence.
- R6: A sequence has three phases. First, rst_oe=1 and rst_out=1 for the pre-delay. Next, rst_out=0 for PULSE_CYC cycles. Then rst_out=1 for the hold time. After that, rst_oe returns to 0. The channel's boot_sel bit is 0 for the whole sequence and returns to 1 in the same cycle that rst_oe drops.
- R7: Channel 0 uses PRE_A_CYC and HOLD_A_CYC. Channel 1 uses PRE_B_CYC and HOLD_B_CYC.
- R8: busy is 1 exactly in the cycles where rst_oe is 1.
- R9: An edge on the armed channel that is not the expected next step puts the block in a locked wait. No sequence starts until the timeout has returned the block to idle.
- R10: The block returns to idle once TIMEOUT_TICKS ticks pass with no accepted event. This applies after a completed sequence, after a lockout, or while armed. After a completed sequence, further requests are ignored until that happens.
- R11: Every accepted or unexpected event restarts the timeout. A slow but valid three-edge sequence therefore succeeds even when its total length exceeds the timeout, provided each gap is shorter than the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_req_n | input | 2 | Boot request per channel, active low, asynchronous |
| rst_req_n | input | 2 | Reset request per channel, active low, asynchronous |
| boot_sel | output | 2 | Boot-select pin value per channel, idle 1 |
| rst_oe | output | 1 | Drive enable for the shared reset line |
| rst_out | output | 1 | Value driven on the reset line while rst_oe is 1 |
| busy | output | 1 | High while a reset sequence runs |

## Verification
The assertions check the per-cycle invariants on every cycle:
- at most one boot pin is low;
- busy tracks the reset driver;
- the driver value is high whenever it is released;
- nothing is driven during startup;
- the timeout counter stays in range;
- a sequence can start only from the enabled state.

The bench scenarios cover the behaviours that depend on history. These are the phase lengths per channel, lockout by the first channel and the tie between channels, the ignored reset edges in idle and after a sequence, recovery after an unexpected edge, and a slow sequence that survives only because each event restarts the timeout.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [2:0] {
    S_START,
    S_IDLE,
    S_ARMED,
    S_ENABLED,
    S_PULSE,
    S_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_LOW,
    PH_HOLD
  } pulse_phase_e;
endpackage

// File: rtl/req_sync.sv
`timescale 1ns/1ps
module req_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  for (genvar i = 0; i < W; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q[i]   <= 1'b1;
        s2_q[i]   <= 1'b1;
        prev_q[i] <= 1'b1;
      end else begin
        s1_q[i]   <= din[i];
        s2_q[i]   <= s1_q[i];
        prev_q[i] <= s2_q[i];
      end
    end
    assign fall[i] = prev_q[i] & ~s2_q[i];
    assign rise[i] = ~prev_q[i] & s2_q[i];
  end
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer #(
  parameter int TICK_DIV      = 2833,
  parameter int STARTUP_TICKS = 750,
  parameter int TIMEOUT_TICKS = 75
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic startup_done,
  output logic expire
);
  localparam int DW = $clog2(TICK_DIV + 1);
  localparam int SW = $clog2(STARTUP_TICKS + 1);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);

  logic [DW-1:0] div_q;
  logic [SW-1:0] st_q;
  logic [TW-1:0] to_q;
  logic          tick;

  assign tick = (div_q == DW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else if (tick) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= '0;
      startup_done <= 1'b0;
    end else if (!startup_done && tick) begin
      if (st_q == SW'(STARTUP_TICKS - 1)) startup_done <= 1'b1;
      else st_q <= st_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !run) to_q <= '0;
    else if (tick) begin
      if (to_q == TW'(TIMEOUT_TICKS - 1)) to_q <= '0;
      else to_q <= to_q + 1'b1;
    end
  end

  assign expire = run && !restart && tick && (to_q == TW'(TIMEOUT_TICKS - 1));

  assert_timeout_bound_R10: assert property (@(posedge clk) disable iff (rst)
    to_q < TW'(TIMEOUT_TICKS));
  assert_startup_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    startup_done |=> startup_done);
endmodule

// File: rtl/pulse_gen.sv
`timescale 1ns/1ps
module pulse_gen
  import boot_seq_pkg::*;
#(
  parameter int PRE_A_CYC  = 4250,
  parameter int PRE_B_CYC  = 425,
  parameter int PULSE_CYC  = 4250,
  parameter int HOLD_A_CYC = 42500,
  parameter int HOLD_B_CYC = 8500
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        ch,
  output logic [1:0]  boot_sel,
  output logic        rst_oe,
  output logic        rst_out,
  output logic        busy,
  output logic        done
);
  localparam int MAX_PRE  = (PRE_A_CYC > PRE_B_CYC) ? PRE_A_CYC : PRE_B_CYC;
  localparam int MAX_HOLD = (HOLD_A_CYC > HOLD_B_CYC) ? HOLD_A_CYC : HOLD_B_CYC;
  localparam int MAX_PH   = (MAX_PRE > MAX_HOLD) ?
                            ((MAX_PRE > PULSE_CYC) ? MAX_PRE : PULSE_CYC) :
                            ((MAX_HOLD > PULSE_CYC) ? MAX_HOLD : PULSE_CYC);
  localparam int CW = $clog2(MAX_PH + 1);

  pulse_phase_e  phase_q;
  logic [CW-1:0] cnt_q;
  logic          ch_q;
  logic [CW-1:0] pre_len, hold_len;

  assign pre_len  = ch   ? CW'(PRE_B_CYC - 1)  : CW'(PRE_A_CYC - 1);
  assign hold_len = ch_q ? CW'(HOLD_B_CYC - 1) : CW'(HOLD_A_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      ch_q     <= 1'b0;
      boot_sel <= 2'b11;
      rst_oe   <= 1'b0;
      rst_out  <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q      <= PH_PRE;
          cnt_q        <= pre_len;
          ch_q         <= ch;
          boot_sel[ch] <= 1'b0;
          rst_oe       <= 1'b1;
          rst_out      <= 1'b1;
          busy         <= 1'b1;
        end
        PH_PRE: if (cnt_q == '0) begin
          phase_q <= PH_LOW;
          cnt_q   <= CW'(PULSE_CYC - 1);
          rst_out <= 1'b0;
        end else cnt_q <= cnt_q - 1'b1;
        PH_LOW: if (cnt_q == '0) begin
          phase_q <= PH_HOLD;
          cnt_q   <= hold_len;
          rst_out <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_q == '0) begin
          phase_q  <= PH_IDLE;
          boot_sel <= 2'b11;
          rst_oe   <= 1'b0;
          busy     <= 1'b0;
          done     <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_busy_tracks_drive_R8: assert property (@(posedge clk) disable iff (rst)
    busy == rst_oe);
  assert_released_high_R6: assert property (@(posedge clk) disable iff (rst)
    !rst_oe |-> rst_out);
  assert_boot_low_while_driving_R6: assert property (@(posedge clk) disable iff (rst)
    rst_oe |-> (boot_sel != 2'b11));
  assert_single_boot_low_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~boot_sel));
endmodule

// File: rtl/boot_entry_seq.sv
`timescale 1ns/1ps
module boot_entry_seq
  import boot_seq_pkg::*;
#(
  parameter int CLK_HZ        = 4_250_000,
  parameter int TICK_HZ       = 1500,
  parameter int TICK_DIV      = CLK_HZ / TICK_HZ,
  parameter int STARTUP_TICKS = 750,
  parameter int TIMEOUT_TICKS = 75,
  parameter int PRE_A_CYC     = CLK_HZ / 1000,
  parameter int PRE_B_CYC     = CLK_HZ / 10000,
  parameter int PULSE_CYC     = CLK_HZ / 1000,
  parameter int HOLD_A_CYC    = CLK_HZ / 100,
  parameter int HOLD_B_CYC    = CLK_HZ / 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] boot_req_n,
  input  logic [1:0] rst_req_n,
  output logic [1:0] boot_sel,
  output logic       rst_oe,
  output logic       rst_out,
  output logic       busy
);
  localparam int NLINES = 2 * NUM_CH;

  logic [NLINES-1:0] fall, rise;
  logic [1:0]        b_fall, b_rise, r_fall, r_rise;
  seq_state_e        state_q, state_d;
  logic              ch_q, ch_d;
  logic              evt, start, run, restart, expire, startup_done, pg_done;
  logic              own_other;

  req_sync #(.W(NLINES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({rst_req_n, boot_req_n}),
    .fall (fall),
    .rise (rise)
  );

  assign b_fall = fall[1:0];
  assign b_rise = rise[1:0];
  assign r_fall = fall[3:2];
  assign r_rise = rise[3:2];

  // Any edge on the owning channel other than the one expected next.
  always_comb begin
    own_other = 1'b0;
    if (state_q == S_ARMED)
      own_other = r_rise[ch_q] | b_fall[ch_q] | b_rise[ch_q];
    else if (state_q == S_ENABLED)
      own_other = r_fall[ch_q] | b_fall[ch_q] | b_rise[ch_q];
  end

  always_comb begin
    evt = 1'b0;
    case (state_q)
      S_IDLE:    evt = |b_fall;
      S_ARMED:   evt = r_fall[ch_q] | own_other;
      S_ENABLED: evt = r_rise[ch_q] | own_other;
      default:   evt = 1'b0;
    endcase
  end

  assign run     = (state_q != S_START) && (state_q != S_IDLE);
  assign restart = evt | busy | pg_done;

  tick_timer #(
    .TICK_DIV      (TICK_DIV),
    .STARTUP_TICKS (STARTUP_TICKS),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .restart      (restart),
    .run          (run),
    .startup_done (startup_done),
    .expire       (expire)
  );

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    start   = 1'b0;
    case (state_q)
      S_START: if (startup_done) state_d = S_IDLE;
      S_IDLE: begin
        if (b_fall[0]) begin
          state_d = S_ARMED;
          ch_d    = 1'b0;
        end else if (b_fall[1]) begin
          state_d = S_ARMED;
          ch_d    = 1'b1;
        end
      end
      S_ARMED: begin
        if (r_fall[ch_q])   state_d = S_ENABLED;
        else if (own_other) state_d = S_WAIT;
        else if (expire)    state_d = S_IDLE;
      end
      S_ENABLED: begin
        if (r_rise[ch_q]) begin
          state_d = S_PULSE;
          start   = 1'b1;
        end else if (own_other) state_d = S_WAIT;
        else if (expire)        state_d = S_IDLE;
      end
      S_PULSE: if (pg_done) state_d = S_WAIT;
      S_WAIT:  if (expire)  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_START;
      ch_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
    end
  end

  pulse_gen #(
    .PRE_A_CYC  (PRE_A_CYC),
    .PRE_B_CYC  (PRE_B_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .HOLD_A_CYC (HOLD_A_CYC),
    .HOLD_B_CYC (HOLD_B_CYC)
  ) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ch       (ch_q),
    .boot_sel (boot_sel),
    .rst_oe   (rst_oe),
    .rst_out  (rst_out),
    .busy     (busy),
    .done     (pg_done)
  );

  assert_quiet_in_startup_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_START) |-> (!rst_oe && boot_sel == 2'b11));
  assert_pulse_from_enabled_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(state_q == S_ENABLED));
  assert_idle_not_driving_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> !busy);
endmodule

// File: tb/boot_entry_seq_bench.sv
`timescale 1ns/1ps
module boot_entry_seq_bench;
  localparam int TICK_DIV = 4, STARTUP = 10, TIMEOUT = 30;
  localparam int PRE_A = 20, PRE_B = 5, PULSE = 16, HOLD_A = 40, HOLD_B = 12;

  typedef struct {int ch; int pre; int low; int hold;} rec_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] boot_req_n = 2'b11;
  logic [1:0] rst_req_n  = 2'b11;
  logic [1:0] boot_sel;
  logic       rst_oe, rst_out, busy;

  int   n_chk = 0, n_bad = 0, n_obs = 0;
  bit   finished = 1'b0;
  rec_t exp_q[$];

  always #2 clk = ~clk;

  boot_entry_seq #(
    .TICK_DIV(TICK_DIV), .STARTUP_TICKS(STARTUP), .TIMEOUT_TICKS(TIMEOUT),
    .PRE_A_CYC(PRE_A), .PRE_B_CYC(PRE_B), .PULSE_CYC(PULSE),
    .HOLD_A_CYC(HOLD_A), .HOLD_B_CYC(HOLD_B)
  ) u_boot_entry_seq (
    .clk(clk), .rst(rst), .boot_req_n(boot_req_n), .rst_req_n(rst_req_n),
    .boot_sel(boot_sel), .rst_oe(rst_oe), .rst_out(rst_out), .busy(busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input int ch);
    rec_t r;
    r.ch   = ch;
    r.pre  = (ch == 0) ? PRE_A : PRE_B;
    r.low  = PULSE;
    r.hold = (ch == 0) ? HOLD_A : HOLD_B;
    exp_q.push_back(r);
  endtask

  // Reset-request fall then rise on one channel.
  task automatic rst_pair(input int ch);
    rst_req_n[ch] = 1'b0;
    wait_cyc(6);
    rst_req_n[ch] = 1'b1;
    wait_cyc(6);
  endtask

  // Monitor: measure each sequence at the ports and compare with the queue.
  initial begin
    bit in_seq = 1'b0;
    int ph = 0, pre = 0, low = 0, hold = 0, bl = 0, och = 0, busy_bad = 0;
    forever begin
      @(negedge clk);
      if (busy !== rst_oe) busy_bad++;
      if (rst_oe) begin
        if (!in_seq) begin
          in_seq = 1'b1;
          ph = 0; pre = 0; low = 0; hold = 0; bl = 0; busy_bad = 0;
          och = (boot_sel[0] == 1'b0) ? 0 : 1;
        end
        if (boot_sel[och] == 1'b0) bl++;
        if (rst_out == 1'b0) begin
          low++;
          ph = 1;
        end else if (ph == 0) pre++;
        else hold++;
      end else if (in_seq) begin
        in_seq = 1'b0;
        n_obs++;
        if (exp_q.size() == 0) begin
          chk("R5", "unexpected sequence", 1, 0);
        end else begin
          rec_t e;
          e = exp_q.pop_front();
          chk("R7", "channel", och, e.ch);
          chk("R7", "pre-delay cycles", pre, e.pre);
          chk("R6", "reset low cycles", low, e.low);
          chk("R7", "hold cycles", hold, e.hold);
          chk("R6", "boot low cycles", bl, pre + low + hold);
          chk("R6", "boot released with driver", int'(boot_sel), 3);
          chk("R8", "busy mismatches", busy_bad, 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    chk("R1", "boot_sel after reset", int'(boot_sel), 3);
    chk("R1", "rst_oe after reset", int'(rst_oe), 0);
    chk("R1", "busy after reset", int'(busy), 0);

    // R2: boot falls inside the startup window, reset pair afterwards.
    boot_req_n[0] = 1'b0;
    wait_cyc(6);
    boot_req_n[0] = 1'b1;
    wait_cyc(60);
    rst_pair(0);
    wait_cyc(100);
    chk("R2", "sequences after startup glitch", n_obs, 0);

    // R3: reset pair on channel 1 in idle has no effect.
    rst_pair(1);
    wait_cyc(100);
    chk("R3", "sequences from idle reset edges", n_obs, 0);

    // R5/R6/R7: full sequence on channel 0.
    boot_req_n[0] = 1'b0;
    wait_cyc(6);
    push_exp(0);
    rst_pair(0);
    wait_cyc(100);
    chk("R5", "pending expected after ch0", exp_q.size(), 0);
    // R10: requests after a completed sequence are ignored.
    base = n_obs;
    rst_pair(0);
    wait_cyc(40);
    chk("R10", "sequences before timeout", n_obs - base, 0);
    boot_req_n[0] = 1'b1;
    wait_cyc(250);

    // R7: channel 1 timing.
    boot_req_n[1] = 1'b0;
    wait_cyc(6);
    push_exp(1);
    rst_pair(1);
    wait_cyc(100);
    chk("R7", "pending expected after ch1", exp_q.size(), 0);
    boot_req_n[1] = 1'b1;
    wait_cyc(250);

    // R4: channel 0 arms first, channel 1 locked out.
    base = n_obs;
    boot_req_n[0] = 1'b0;
    wait_cyc(6);
    boot_req_n[1] = 1'b0;
    wait_cyc(6);
    rst_pair(1);
    wait_cyc(20);
    chk("R4", "sequences from locked-out channel", n_obs - base, 0);
    push_exp(0);
    rst_pair(0);
    wait_cyc(100);
    chk("R4", "pending expected owner ch0", exp_q.size(), 0);
    boot_req_n = 2'b11;
    wait_cyc(250);

    // R4: simultaneous boot falls, channel 0 wins.
    base = n_obs;
    boot_req_n = 2'b00;
    wait_cyc(6);
    rst_pair(1);
    wait_cyc(20);
    chk("R4", "tie: sequences from ch1", n_obs - base, 0);
    push_exp(0);
    rst_pair(0);
    wait_cyc(100);
    chk("R4", "tie: pending expected ch0", exp_q.size(), 0);
    boot_req_n = 2'b11;
    wait_cyc(250);

    // R9: unexpected boot rise on the armed channel locks the block.
    base = n_obs;
    boot_req_n[0] = 1'b0;
    wait_cyc(6);
    boot_req_n[0] = 1'b1;
    wait_cyc(6);
    boot_req_n[0] = 1'b0;
    wait_cyc(6);
    rst_pair(0);
    wait_cyc(20);
    chk("R9", "sequences while locked", n_obs - base, 0);
    boot_req_n[0] = 1'b1;
    wait_cyc(250);
    // R10: recovery after the timeout.
    boot_req_n[0] = 1'b0;
    wait_cyc(6);
    push_exp(0);
    rst_pair(0);
    wait_cyc(100);
    chk("R10", "pending expected after recovery", exp_q.size(), 0);
    boot_req_n[0] = 1'b1;
    wait_cyc(250);

    // R10: armed channel times out back to idle.
    base = n_obs;
    boot_req_n[1] = 1'b0;
    wait_cyc(200);
    rst_pair(1);
    wait_cyc(40);
    chk("R10", "sequences after armed timeout", n_obs - base, 0);
    boot_req_n[1] = 1'b1;
    wait_cyc(20);

    // R11: slow sequence, each gap below the timeout, total above it.
    boot_req_n[0] = 1'b0;
    wait_cyc(90);
    rst_req_n[0] = 1'b0;
    wait_cyc(90);
    push_exp(0);
    rst_req_n[0] = 1'b1;
    wait_cyc(100);
    chk("R11", "pending expected slow sequence", exp_q.size(), 0);
    boot_req_n[0] = 1'b1;
    wait_cyc(250);

    chk("R8", "busy idle at end", int'(busy), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule